// File: doc/BRIEF.md
# NRZI Bit-Stuffing Packet Transmitter

This block turns a stream of packet bytes into full-speed serial bus line states, one symbol per bit-time strobe. When a packet is offered, the block first sends a synchronisation byte. It then sends the data bytes least significant bit first. A zero is forced into the stream after any run of six ones. Every bit is NRZI-encoded onto the line. The packet closes with an end-of-packet sequence, after which the block releases the line.

An upstream framer holds `valid_i` high for the whole packet and marks the final byte with `last_i`. A byte is consumed in the cycle where `ready_o` is high. `ready_o` only rises on a bit-time strobe, when that byte's first bit goes onto the line. The line state and the output enable feed a transceiver. `stuff_o` marks the bit-times that carry an inserted zero.

Top module: `nrzi_stuff_tx`

## Requirements
- R1: While reset is held, `oe_o`, `ready_o` and `stuff_o` are low and `line_o` is J. Line codes: J = 2'b01, K = 2'b10, SE0 = 2'b00.
- R2: While no packet is in flight, `oe_o` stays low and `line_o` stays J. With `valid_i` low, `data_i` and `last_i` have no effect.
- R3: A packet starts on the first strobe with `valid_i` high. Its first eight bit-times carry the sync byte 0x80, sent LSB first (seven zeros, then a one): K,J,K,J,K,J,K,K.
- R4: Encoding is NRZI. A 0 toggles the line between J and K and a 1 leaves it unchanged. Each packet starts from J.
- R5: Data bytes are sent least significant bit first, in the order they are handshaken.
- R6: After six consecutive ones, the next bit-time carries an inserted 0, with `stuff_o` high for that bit-time. The insertion restarts the run count.
- R7: The final one of the sync byte counts as the first one of a run. A byte starting with five ones therefore gets a stuffed zero after its fifth bit.
- R8: When the last data bits complete a run of six ones, a stuffed zero is sent before the end-of-packet.
- R9: The end-of-packet is two SE0 bit-times and then one J bit-time with `oe_o` high. On the following strobe `oe_o` falls and `line_o` stays J.
- R10: `ready_o` is high only in a strobe cycle on a byte's first data bit, never during sync, stuffing or end-of-packet. Exactly one handshake occurs per byte.
- R11: `line_o`, `oe_o` and `stuff_o` change only on clock edges where `bit_en_i` is high.
- R12: A new packet may start on the strobe that immediately follows the strobe on which `oe_o` fell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle strobe per bit-time |
| data_i | input | BYTE_W | Packet byte |
| valid_i | input | 1 | Byte offered; held high for the whole packet |
| last_i | input | 1 | Offered byte is the final one of the packet |
| ready_o | output | 1 | Byte taken in this cycle |
| line_o | output | 2 | Line state: J 2'b01, K 2'b10, SE0 2'b00 |
| oe_o | output | 1 | Line driver enable |
| stuff_o | output | 1 | Current bit-time carries a stuffed zero |

## Verification
The assertions assume that `bit_en_i` is a single-cycle pulse separated by idle cycles, and that `valid_i` stays high from a packet's start to its last handshake with a byte already present at each ready slot. The bench produces the strobe once every four clocks from a free-running divider. It raises `valid_i` with the first byte before the start, changes the byte only after a handshake, and drops `valid_i` only after the last byte is taken. This keeps every stimulus within those assumptions.

// File: rtl/nst_pkg.sv
package nst_pkg;
  typedef enum logic [1:0] {
    LINE_SE0 = 2'b00,
    LINE_J   = 2'b01,
    LINE_K   = 2'b10
  } line_e;

  typedef enum logic [1:0] {
    SYM_BIT,
    SYM_SE0,
    SYM_J
  } sym_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SYNC,
    PH_DATA,
    PH_EOP0,
    PH_EOP1,
    PH_EOPJ,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/nst_run_ctr.sv
module nst_run_ctr #(
  parameter int unsigned RUN_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  input  logic bit_i,
  output logic due_o
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] cnt_q;

  // a zero (data or stuffed) breaks the run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (clear_i || (step_i && !bit_i)) cnt_q <= '0;
    else if (step_i)                     cnt_q <= cnt_q + 1'b1;
  end

  assign due_o = (cnt_q == CW'(RUN_LEN));
endmodule

// File: rtl/nst_seq.sv
module nst_seq
  import nst_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              due_i,
  output logic              ready_o,
  output logic              clear_o,
  output logic              step_o,
  output logic              bit_step_o,
  output sym_e              sym_o,
  output logic              bit_o,
  output logic              oe_o,
  output logic              stuff_o
);
  localparam int unsigned IW = $clog2(BYTE_W);
  localparam logic [IW-1:0] IDX_END = IW'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] SYNC_PAT = {1'b1, {(BYTE_W-1){1'b0}}};

  phase_e            ph_q, ph_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [BYTE_W-1:0] shf_q, shf_d;
  logic              last_q, last_d, cur_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      idx_q  <= '0;
      shf_q  <= '0;
      last_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      shf_q  <= shf_d;
      last_q <= last_d;
    end
  end

  always_comb begin
    ph_d     = ph_q;
    idx_d    = idx_q;
    shf_d    = shf_q;
    last_d   = last_q;
    cur_last = last_q;
    step_o   = 1'b0;
    sym_o    = SYM_BIT;
    bit_o    = 1'b0;
    oe_o     = 1'b1;
    stuff_o  = 1'b0;
    ready_o  = 1'b0;
    clear_o  = 1'b0;
    if (bit_en_i) begin
      case (ph_q)
        PH_IDLE: begin
          oe_o = 1'b0;
          if (valid_i) begin
            step_o  = 1'b1;
            oe_o    = 1'b1;
            clear_o = 1'b1;
            bit_o   = SYNC_PAT[0];
            idx_d   = IW'(1);
            ph_d    = PH_SYNC;
          end
        end
        PH_SYNC: begin
          step_o = 1'b1;
          bit_o  = SYNC_PAT[idx_q];
          idx_d  = idx_q + 1'b1;
          if (idx_q == IDX_END) begin
            idx_d = '0;
            ph_d  = PH_DATA;
          end
        end
        PH_DATA: begin
          step_o = 1'b1;
          if (due_i) begin
            stuff_o = 1'b1;
          end else begin
            if (idx_q == '0) begin
              // byte is taken as its first bit goes out
              ready_o  = 1'b1;
              bit_o    = data_i[0];
              shf_d    = data_i >> 1;
              last_d   = last_i;
              cur_last = last_i;
            end else begin
              bit_o = shf_q[0];
              shf_d = shf_q >> 1;
            end
            idx_d = idx_q + 1'b1;
            if (idx_q == IDX_END) begin
              idx_d = '0;
              if (cur_last) ph_d = PH_EOP0;
            end
          end
        end
        PH_EOP0: begin
          step_o = 1'b1;
          if (due_i) begin
            stuff_o = 1'b1;
          end else begin
            sym_o = SYM_SE0;
            ph_d  = PH_EOP1;
          end
        end
        PH_EOP1: begin
          step_o = 1'b1;
          sym_o  = SYM_SE0;
          ph_d   = PH_EOPJ;
        end
        PH_EOPJ: begin
          step_o = 1'b1;
          sym_o  = SYM_J;
          ph_d   = PH_DONE;
        end
        PH_DONE: begin
          step_o = 1'b1;
          sym_o  = SYM_J;
          oe_o   = 1'b0;
          ph_d   = PH_IDLE;
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  assign bit_step_o = step_o && (sym_o == SYM_BIT);
endmodule

// File: rtl/nst_line_drv.sv
module nst_line_drv
  import nst_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  step_i,
  input  sym_e  sym_i,
  input  logic  bit_i,
  input  logic  oe_i,
  input  logic  stuff_i,
  output line_e line_o,
  output logic  oe_o,
  output logic  stuff_o
);
  line_e line_q, lvl_q, lvl_nxt;
  logic  oe_q, stuff_q;

  // NRZI level kept apart from the line so SE0 does not disturb it
  always_comb lvl_nxt = bit_i ? lvl_q : ((lvl_q == LINE_J) ? LINE_K : LINE_J);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= LINE_J;
      lvl_q   <= LINE_J;
      oe_q    <= 1'b0;
      stuff_q <= 1'b0;
    end else if (step_i) begin
      oe_q    <= oe_i;
      stuff_q <= stuff_i;
      case (sym_i)
        SYM_BIT: begin
          line_q <= lvl_nxt;
          lvl_q  <= lvl_nxt;
        end
        SYM_SE0: line_q <= LINE_SE0;
        default: begin
          line_q <= LINE_J;
          lvl_q  <= LINE_J;
        end
      endcase
    end
  end

  assign line_o  = line_q;
  assign oe_o    = oe_q;
  assign stuff_o = stuff_q;
endmodule

// File: rtl/nrzi_stuff_tx.sv
module nrzi_stuff_tx
  import nst_pkg::*;
#(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned RUN_LEN = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              last_i,
  output logic              ready_o,
  output logic [1:0]        line_o,
  output logic              oe_o,
  output logic              stuff_o
);
  logic  due, clear, step, bit_step, bit_val, oe_nxt, stuff_nxt;
  sym_e  sym;
  line_e line_w;

  nst_seq #(.BYTE_W(BYTE_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (bit_en_i),
    .valid_i    (valid_i),
    .last_i     (last_i),
    .data_i     (data_i),
    .due_i      (due),
    .ready_o    (ready_o),
    .clear_o    (clear),
    .step_o     (step),
    .bit_step_o (bit_step),
    .sym_o      (sym),
    .bit_o      (bit_val),
    .oe_o       (oe_nxt),
    .stuff_o    (stuff_nxt)
  );

  nst_run_ctr #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .step_i  (bit_step),
    .bit_i   (bit_val),
    .due_o   (due)
  );

  nst_line_drv u_line (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .sym_i   (sym),
    .bit_i   (bit_val),
    .oe_i    (oe_nxt),
    .stuff_i (stuff_nxt),
    .line_o  (line_w),
    .oe_o    (oe_o),
    .stuff_o (stuff_o)
  );

  assign line_o = line_w;
endmodule

// File: rtl/nrzi_stuff_tx_chk.sv
module nrzi_stuff_tx_chk
  import nst_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_en_i,
  input logic       ready_o,
  input logic [1:0] line_o,
  input logic       oe_o,
  input logic       stuff_o
);
  // R11
  bit_time_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(line_o) && $stable(oe_o) && $stable(stuff_o));

  // R10
  ready_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> bit_en_i && oe_o);

  // R10
  ready_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !stuff_o && (line_o != LINE_SE0));

  // R9
  release_j_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> (line_o == LINE_J));

  // R6
  stuff_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stuff_o) |-> oe_o && (line_o != $past(line_o)));

  // R2
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (line_o == LINE_J) && !stuff_o);
endmodule

bind nrzi_stuff_tx nrzi_stuff_tx_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bit_en_i (bit_en_i),
  .ready_o  (ready_o),
  .line_o   (line_o),
  .oe_o     (oe_o),
  .stuff_o  (stuff_o)
);

// File: tb/nrzi_stuff_tx_test.sv
module nrzi_stuff_tx_test;
  import nst_pkg::*;

  typedef logic [7:0] byte_q_t[$];
  typedef struct {
    logic       oe;
    logic [1:0] line;
    logic       stuff;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic       valid_i = 1'b0;
  logic       last_i = 1'b0;
  logic       ready_o, oe_o, stuff_o;
  logic [1:0] line_o;

  int checks = 0;
  int errors = 0;

  nrzi_stuff_tx uut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .data_i   (data_i),
    .valid_i  (valid_i),
    .last_i   (last_i),
    .ready_o  (ready_o),
    .line_o   (line_o),
    .oe_o     (oe_o),
    .stuff_o  (stuff_o)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit-time strobe every fourth clock
  logic [1:0] div = 2'd0;
  logic       bit_gate = 1'b0;
  always @(negedge clk) begin
    div      <= div + 2'd1;
    bit_en_i <= bit_gate && (div == 2'd3);
  end

  logic took = 1'b0;
  logic edge_seen = 1'b0;
  always @(posedge clk) begin
    took      <= ready_o;
    edge_seen <= bit_en_i;
    if (rst_ni) check("R10 ready outside strobe", 32'(ready_o & ~bit_en_i), 32'd0);
  end

  // scoreboard
  exp_t       expq[$];
  exp_t       cur;
  logic       in_pkt = 1'b0;
  logic       prev_oe = 1'b0;
  logic [1:0] prev_line = LINE_J;
  int         gap = 0;
  logic       exp_b2b = 1'b0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (edge_seen) begin
        if (oe_o && !prev_oe && exp_b2b) check("R12 idle gap", 32'(gap), 32'd1);
        if (oe_o) gap = 0; else gap++;
        if (expq.size() != 0 && (oe_o || in_pkt)) begin
          cur = expq.pop_front();
          check({cur.req, " oe"},    32'(oe_o),    32'(cur.oe));
          check({cur.req, " line"},  32'(line_o),  32'(cur.line));
          check({cur.req, " stuff"}, 32'(stuff_o), 32'(cur.stuff));
          in_pkt = cur.oe;
        end else if (oe_o) begin
          check("R2 unexpected oe", 32'(oe_o), 32'd0);
        end
        prev_oe = oe_o;
      end else begin
        check("R11 mid-bit line", 32'(line_o), 32'(prev_line));
      end
      prev_line = line_o;
    end
  end

  // reference model state
  logic [1:0] m_lvl;
  int         m_ones;
  logic       m_sync_run;

  task automatic push_sym(input logic oe, input logic [1:0] line, input logic stuff, input string req);
    exp_t e;
    e.oe = oe; e.line = line; e.stuff = stuff; e.req = req;
    expq.push_back(e);
  endtask

  function automatic logic [1:0] flip(input logic [1:0] l);
    return (l == LINE_J) ? LINE_K : LINE_J;
  endfunction

  task automatic push_bit(input logic b, input string req, input logic is_last);
    string sreq;
    if (!b) begin
      m_lvl = flip(m_lvl);
      m_ones = 0;
      m_sync_run = 1'b0;
    end else begin
      m_ones++;
    end
    push_sym(1'b1, m_lvl, 1'b0, req);
    if (m_ones == 6) begin
      if (m_sync_run) sreq = "R7 stuff after sync one";
      else if (is_last) sreq = "R8 stuff before EOP";
      else sreq = "R6 stuff";
      m_lvl = flip(m_lvl);
      push_sym(1'b1, m_lvl, 1'b1, sreq);
      m_ones = 0;
      m_sync_run = 1'b0;
    end
  endtask

  task automatic send(input byte_q_t pkt, input logic b2b);
    int hs = 0;
    exp_b2b = b2b;
    m_lvl = LINE_J;
    m_ones = 0;
    m_sync_run = 1'b0;
    for (int i = 0; i < 8; i++) push_bit((i == 7), "R3 sync", 1'b0);
    m_sync_run = 1'b1;
    for (int i = 0; i < pkt.size(); i++)
      for (int b = 0; b < 8; b++)
        push_bit(pkt[i][b], "R4 R5 data", (i == pkt.size() - 1) && (b == 7));
    push_sym(1'b1, LINE_SE0, 1'b0, "R9 se0");
    push_sym(1'b1, LINE_SE0, 1'b0, "R9 se0");
    push_sym(1'b1, LINE_J,   1'b0, "R9 closing J");
    push_sym(1'b0, LINE_J,   1'b0, "R9 release");
    for (int i = 0; i < pkt.size(); i++) begin
      valid_i <= 1'b1;
      data_i  <= pkt[i];
      last_i  <= (i == pkt.size() - 1);
      do @(negedge clk); while (!took);
      hs++;
    end
    valid_i <= 1'b0;
    last_i  <= 1'b0;
    while (expq.size() != 0) @(negedge clk);
    check("R10 handshakes per packet", 32'(hs), 32'(pkt.size()));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  byte_q_t tx;

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check("R1 oe in reset",    32'(oe_o),    32'd0);
    check("R1 line in reset",  32'(line_o),  32'(LINE_J));
    check("R1 ready in reset", 32'(ready_o), 32'd0);
    check("R1 stuff in reset", 32'(stuff_o), 32'd0);
    rst_ni   = 1'b1;
    bit_gate = 1'b1;
    // R2: data and last toggle while valid is low
    data_i = 8'hFF;
    last_i = 1'b1;
    repeat (24) @(negedge clk);
    check("R2 idle oe",   32'(oe_o),   32'd0);
    check("R2 idle line", 32'(line_o), 32'(LINE_J));
    last_i = 1'b0;
    @(negedge clk);

    tx = {8'h00};               // R4 all zeros
    send(tx, 1'b0);
    repeat (9) @(negedge clk);
    tx = {8'h1F};               // R7 run begins with sync one
    send(tx, 1'b0);
    repeat (5) @(negedge clk);
    tx = {8'hFC};               // R8 run completes on last bit
    send(tx, 1'b0);
    tx = {8'hFF, 8'hFF, 8'hA5}; // R6 runs across bytes
    send(tx, 1'b0);
    tx = {8'h3C, 8'hC3, 8'h7E, 8'h81};
    send(tx, 1'b0);
    tx = {8'hFF, 8'hFF, 8'hFF};
    send(tx, 1'b0);
    tx = {8'h55};               // R12 immediately after previous release
    send(tx, 1'b1);
    tx = {8'hE0, 8'h0F};
    send(tx, 1'b1);
    exp_b2b = 1'b0;
    repeat (16) @(negedge clk);
    check("R2 idle after traffic", 32'(oe_o), 32'd0);
    finish_run();
  end
endmodule